// File: doc/BRIEF.md
# GPIO Port with Pin Interrupt Detection

This block is a bus-mapped general-purpose I/O port for up to 32 pins. Software reaches it through a simple 32-bit word read/write bus inside a 1 KiB register window. The port holds an output data word, a per-pin direction word and a write mask. It also offers write-only ports that set, clear or invert chosen output bits in a single access, so no read-modify-write is needed.

Every pin can raise an interrupt. The trigger for each pin comes from three configuration bits. One bit picks level or edge detection. One bit picks both edges. The third bit picks the polarity, or the edge direction when only one edge is used. Pin inputs pass through a two-flop synchronizer before any use. Software sees three views of the pins: the unlatched trigger condition, the enabled status, and a latched record of edges that clears when it is read. A single interrupt line is the OR of all enabled status bits.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset, the output data, direction, trigger configuration, enable and edge record are all zero, the write mask is all ones, and `irq_out`, `pin_out`, `pin_oe` and `bus_rdata` are 0.
- R2: The direction word (offset 0x20) drives `pin_oe` bit for bit, where 1 means the pin is driven.
- R3: A write to offset 0x08 changes only the output bits whose mask bit (offset 0x1C) is 1. A read of 0x08 returns output AND mask. Offset 0x0C reads and writes the full output word with no mask.
- R4: Writing offsets 0x10, 0x14 and 0x18 sets, clears or inverts the output bits at the positions written as 1, and leaves the other bits alone. These three offsets read as zero.
- R5: Offset 0x04 returns the pin levels after a two-flop synchronizer. Offset 0x00 returns that value ANDed with the mask.
- R6: With the sense bit (0x34) at 1, a pin's trigger at 0x44 is its level when its event bit (0x3C) is 1, and the inverse of its level when the event bit is 0.
- R7: With the sense bit at 0 and the both-edge bit (0x38) at 0, an event bit of 1 detects rising edges and 0 detects falling edges.
- R8: With the sense bit at 0 and the both-edge bit at 1, both edges are detected whatever the event bit holds.
- R9: Offset 0x4C latches every detected edge of an edge-mode pin. A read returns the latched bits and clears them. An edge detected in the same cycle as that read stays latched.
- R10: The status at 0x48 is enable (0x40) AND trigger for level pins, and enable AND latched edge for edge pins. `irq_out` is 1 exactly when any status bit is 1.
- R11: Offset 0x3FC returns the `PERIPH_ID` parameter. Unmapped offsets read as zero.
- R12: Writes to 0x00, 0x04, 0x44, 0x48 and 0x4C have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Access strobe for one cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 10 | Byte address in the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the read strobe |
| pin_in | input | NPINS | Pin levels from the pads |
| pin_out | output | NPINS | Output data to the pads |
| pin_oe | output | NPINS | Output enable per pin |
| irq_out | output | 1 | Combined interrupt |

## Verification
Two things can happen in the same cycle: a read of the edge record, which clears it, and a newly detected edge that sets it. The bench times a pin change so that the synchronized edge arrives exactly on the clock edge that samples the read. It does this once on a different pin and once on the pin that is already latched. The first read must show only the old bits. A second read must still show the new edge. A third read must come back clear.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned BUS_W  = 32;
  localparam int unsigned ADDR_W = 10;

  localparam logic [ADDR_W-1:0] A_DIN      = 10'h000;
  localparam logic [ADDR_W-1:0] A_PADLVL   = 10'h004;
  localparam logic [ADDR_W-1:0] A_DOUT     = 10'h008;
  localparam logic [ADDR_W-1:0] A_DOUT_ALL = 10'h00C;
  localparam logic [ADDR_W-1:0] A_SET      = 10'h010;
  localparam logic [ADDR_W-1:0] A_CLR      = 10'h014;
  localparam logic [ADDR_W-1:0] A_TOG      = 10'h018;
  localparam logic [ADDR_W-1:0] A_MASK     = 10'h01C;
  localparam logic [ADDR_W-1:0] A_DIR      = 10'h020;
  localparam logic [ADDR_W-1:0] A_SENSE    = 10'h034;
  localparam logic [ADDR_W-1:0] A_BOTH     = 10'h038;
  localparam logic [ADDR_W-1:0] A_EVT      = 10'h03C;
  localparam logic [ADDR_W-1:0] A_EN       = 10'h040;
  localparam logic [ADDR_W-1:0] A_TRIG     = 10'h044;
  localparam logic [ADDR_W-1:0] A_STAT     = 10'h048;
  localparam logic [ADDR_W-1:0] A_EDGE     = 10'h04C;
  localparam logic [ADDR_W-1:0] A_ID       = 10'h3FC;

  // Edge detection on one pin: cur is this cycle's synchronized level, prv the one before.
  function automatic logic edge_seen(input logic both, input logic evt,
                                     input logic cur, input logic prv);
    logic up, dn;
    up = cur & ~prv;
    dn = ~cur & prv;
    return both ? (up | dn) : (evt ? up : dn);
  endfunction

  // Level detection on one pin: evt gives the active polarity.
  function automatic logic level_seen(input logic evt, input logic cur);
    return evt ? cur : ~cur;
  endfunction
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] cur,
  output logic [W-1:0] prv
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      cur    <= '0;
      prv    <= '0;
    end else begin
      meta_q <= d;
      cur    <= meta_q;
      prv    <= cur;
    end
  end
endmodule

// File: rtl/gpio_irq_trig.sv
module gpio_irq_trig
  import gpio_irq_pkg::*;
(
  input  logic sense,
  input  logic both,
  input  logic evt,
  input  logic cur,
  input  logic prv,
  output logic trig,
  output logic edge_set
);
  logic e_hit;

  always_comb begin
    e_hit    = edge_seen(both, evt, cur, prv);
    trig     = sense ? level_seen(evt, cur) : e_hit;
    edge_set = ~sense & e_hit;
  end
endmodule

// File: rtl/gpio_irq_edge_latch.sv
module gpio_irq_edge_latch #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic [W-1:0] clr_vec,
  output logic [W-1:0] q
);
  // A new edge takes priority over a clear in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= (q & ~clr_vec) | set_vec;
  end
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPINS     = 32,
  parameter logic [31:0] PERIPH_ID = 32'h6A10_0003
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [9:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic              irq_out
);
  localparam int unsigned N = NPINS;
  typedef logic [N-1:0] pins_t;

  pins_t out_q, dir_q, mask_q, sense_q, both_q, evt_q, en_q;
  pins_t sync_cur, sync_prv, trig_vec, edge_set, edge_q, edge_clr, stat_vec;
  pins_t wd;
  logic  wr_hit, rd_hit;
  logic [31:0] rd_mux;

  assign wd     = bus_wdata[N-1:0];
  assign wr_hit = bus_sel & bus_wr;
  assign rd_hit = bus_sel & ~bus_wr;

  gpio_irq_sync #(.W(N)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .cur(sync_cur), .prv(sync_prv)
  );

  for (genvar i = 0; i < N; i++) begin : g_pin
    gpio_irq_trig u_trig (
      .sense(sense_q[i]), .both(both_q[i]), .evt(evt_q[i]),
      .cur(sync_cur[i]), .prv(sync_prv[i]),
      .trig(trig_vec[i]), .edge_set(edge_set[i])
    );
  end

  assign edge_clr = (rd_hit && bus_addr == A_EDGE) ? edge_q : '0;

  gpio_irq_edge_latch #(.W(N)) u_edge (
    .clk(clk), .rst_n(rst_n), .set_vec(edge_set), .clr_vec(edge_clr), .q(edge_q)
  );

  assign stat_vec = en_q & ((sense_q & trig_vec) | (~sense_q & edge_q));
  assign irq_out  = |stat_vec;
  assign pin_out  = out_q;
  assign pin_oe   = dir_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q   <= '0;
      dir_q   <= '0;
      mask_q  <= '1;
      sense_q <= '0;
      both_q  <= '0;
      evt_q   <= '0;
      en_q    <= '0;
    end else if (wr_hit) begin
      case (bus_addr)
        A_DOUT:     out_q   <= (out_q & ~mask_q) | (wd & mask_q);
        A_DOUT_ALL: out_q   <= wd;
        A_SET:      out_q   <= out_q | wd;
        A_CLR:      out_q   <= out_q & ~wd;
        A_TOG:      out_q   <= out_q ^ wd;
        A_MASK:     mask_q  <= wd;
        A_DIR:      dir_q   <= wd;
        A_SENSE:    sense_q <= wd;
        A_BOTH:     both_q  <= wd;
        A_EVT:      evt_q   <= wd;
        A_EN:       en_q    <= wd;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (bus_addr)
      A_DIN:      rd_mux = BUS_W'(sync_cur & mask_q);
      A_PADLVL:   rd_mux = BUS_W'(sync_cur);
      A_DOUT:     rd_mux = BUS_W'(out_q & mask_q);
      A_DOUT_ALL: rd_mux = BUS_W'(out_q);
      A_MASK:     rd_mux = BUS_W'(mask_q);
      A_DIR:      rd_mux = BUS_W'(dir_q);
      A_SENSE:    rd_mux = BUS_W'(sense_q);
      A_BOTH:     rd_mux = BUS_W'(both_q);
      A_EVT:      rd_mux = BUS_W'(evt_q);
      A_EN:       rd_mux = BUS_W'(en_q);
      A_TRIG:     rd_mux = BUS_W'(trig_vec);
      A_STAT:     rd_mux = BUS_W'(stat_vec);
      A_EDGE:     rd_mux = BUS_W'(edge_q);
      A_ID:       rd_mux = PERIPH_ID;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (rd_hit) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk
  import gpio_irq_pkg::*;
#(
  parameter int unsigned N = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         bus_sel,
  input logic         bus_wr,
  input logic [9:0]   bus_addr,
  input logic [31:0]  bus_wdata,
  input logic [N-1:0] pin_out,
  input logic [N-1:0] pin_oe,
  input logic         irq_out,
  input logic [N-1:0] en_q,
  input logic [N-1:0] edge_q,
  input logic [N-1:0] edge_clr,
  input logic [N-1:0] edge_set
);
  logic w_dir, w_set, w_clr, w_tog;
  assign w_dir = bus_sel && bus_wr && bus_addr == A_DIR;
  assign w_set = bus_sel && bus_wr && bus_addr == A_SET;
  assign w_clr = bus_sel && bus_wr && bus_addr == A_CLR;
  assign w_tog = bus_sel && bus_wr && bus_addr == A_TOG;

  p_dir_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    w_dir |=> pin_oe == $past(bus_wdata[N-1:0]));

  p_set_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    w_set |=> pin_out == ($past(pin_out) | $past(bus_wdata[N-1:0])));

  p_clr_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    w_clr |=> pin_out == ($past(pin_out) & ~$past(bus_wdata[N-1:0])));

  p_tog_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    w_tog |=> pin_out == ($past(pin_out) ^ $past(bus_wdata[N-1:0])));

  p_edge_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_q & $past(edge_q & ~edge_clr)) == $past(edge_q & ~edge_clr));

  p_edge_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_q & $past(edge_set)) == $past(edge_set));

  p_irq_needs_en_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> en_q != '0);
endmodule

bind gpio_irq_port gpio_irq_port_chk #(.N(NPINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .pin_out(pin_out),
  .pin_oe(pin_oe), .irq_out(irq_out), .en_q(en_q), .edge_q(edge_q),
  .edge_clr(edge_clr), .edge_set(edge_set)
);

// File: tb/gpio_irq_port_test.sv
`timescale 1ns/1ps
module gpio_irq_port_test;
  localparam int unsigned NP = 8;
  localparam logic [31:0] ID = 32'hA5C3_0101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [9:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out, pin_oe;
  logic irq_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gpio_irq_port #(.NPINS(NP), .PERIPH_ID(ID)) uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq_out(irq_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 pin_out", 32'(pin_out), 0);
    check("R1 pin_oe", 32'(pin_oe), 0);
    check("R1 irq", 32'(irq_out), 0);
    check("R1 rdata", bus_rdata, 0);
    rd(10'h01C, r); check("R1 mask", r, 32'hFF);
    rd(10'h00C, r); check("R1 dout", r, 0);

    // R2 direction
    wr(10'h020, 32'h3C); check("R2 oe", 32'(pin_oe), 32'h3C);
    rd(10'h020, r); check("R2 dir read", r, 32'h3C);

    // R3 masked output write
    wr(10'h01C, 32'h0F);
    wr(10'h008, 32'hFF); check("R3 masked write", 32'(pin_out), 32'h0F);
    wr(10'h00C, 32'hA5); check("R3 full write", 32'(pin_out), 32'hA5);
    rd(10'h008, r); check("R3 masked read", r, 32'h05);
    rd(10'h00C, r); check("R3 full read", r, 32'hA5);
    wr(10'h008, 32'h00); check("R3 masked clear", 32'(pin_out), 32'hA0);

    // R4 set / clear / toggle
    wr(10'h010, 32'h05); check("R4 set", 32'(pin_out), 32'hA5);
    wr(10'h014, 32'h81); check("R4 clear", 32'(pin_out), 32'h24);
    wr(10'h018, 32'hF0); check("R4 toggle", 32'(pin_out), 32'hD4);
    rd(10'h010, r); check("R4 set reads 0", r, 0);
    rd(10'h018, r); check("R4 tog reads 0", r, 0);

    // R5 synchronized input and masked view
    pin_in = 8'h96; settle();
    rd(10'h004, r); check("R5 pad level", r, 32'h96);
    rd(10'h000, r); check("R5 masked in", r, 32'h06);
    wr(10'h01C, 32'hFF);
    pin_in = 8'h00; settle();

    // R11 id and holes
    rd(10'h3FC, r); check("R11 id", r, ID);
    rd(10'h024, r); check("R11 hole 0x24", r, 0);
    rd(10'h200, r); check("R11 hole 0x200", r, 0);

    // R6 R7 R8 R10 sweep of every trigger setting
    wr(10'h040, 32'hFF);
    for (int cfg = 0; cfg < 8; cfg++) begin
      logic s, b, e, up, dn;
      logic [31:0] lvl0, lvl1;
      s = cfg[2]; b = cfg[1]; e = cfg[0];
      up = !s && (b || e);
      dn = !s && (b || !e);
      lvl0 = (s && !e) ? 32'hFF : 0;
      lvl1 = (s && e) ? 32'hFF : 0;
      wr(10'h034, s ? 32'hFF : 0);
      wr(10'h038, b ? 32'hFF : 0);
      wr(10'h03C, e ? 32'hFF : 0);
      pin_in = 8'h00; settle();
      rd(10'h04C, r);
      rd(10'h044, r); check(s ? "R6 level low" : "R7 idle low", r, lvl0);
      check("R10 irq low", 32'(irq_out), (lvl0 != 0) ? 1 : 0);
      pin_in = 8'hFF; settle();
      rd(10'h044, r); check(s ? "R6 level high" : "R7 idle high", r, lvl1);
      rd(10'h048, r); check("R10 status", r, s ? lvl1 : (up ? 32'hFF : 0));
      check("R10 irq", 32'(irq_out), (s ? (lvl1 != 0) : up) ? 1 : 0);
      rd(10'h04C, r); check(b ? "R8 rise" : "R7 rise", r, up ? 32'hFF : 0);
      rd(10'h04C, r); check("R9 cleared", r, 0);
      pin_in = 8'h00; settle();
      rd(10'h04C, r); check(b ? "R8 fall" : "R7 fall", r, dn ? 32'hFF : 0);
    end

    // R10 enable gates status
    wr(10'h034, 0); wr(10'h038, 32'hFF); wr(10'h040, 32'h02);
    pin_in = 8'h01; settle();
    rd(10'h048, r); check("R10 disabled pin", r, 0);
    check("R10 irq off", 32'(irq_out), 0);

    // R12 writes to read-only offsets ignored
    wr(10'h04C, 32'h00); wr(10'h048, 32'hFF); wr(10'h004, 32'hFF); wr(10'h000, 32'hFF);
    rd(10'h004, r); check("R12 pad level kept", r, 32'h01);
    rd(10'h04C, r); check("R12 edge kept", r, 32'h01);

    // R9 collision: edge on another pin arrives with the clearing read
    pin_in = 8'h03; settle();
    pin_in = 8'h07;
    @(negedge clk);
    rd(10'h04C, r); check("R9 read old only", r, 32'h02);
    rd(10'h04C, r); check("R9 new edge kept", r, 32'h04);
    rd(10'h04C, r); check("R9 clear after", r, 0);

    // R9 collision on the already latched pin
    pin_in = 8'h0F; settle();
    pin_in = 8'h07;
    @(negedge clk);
    rd(10'h04C, r); check("R9 same pin read", r, 32'h08);
    rd(10'h04C, r); check("R9 same pin kept", r, 32'h08);
    rd(10'h04C, r); check("R9 same pin clear", r, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule